// File: doc/BRIEF.md
# Register access SPI slave

This block lets a host read and write a bank of 8-bit configuration registers over a four-wire serial link. The serial clock idles low and the select line is active low. Each access is one 16-bit frame inside a single select window. The frame holds a 6-bit register address, a direction bit, a bit that must be 1, and a data byte. On a write, the data byte is stored in the addressed register. On a read, the host clocks in a dummy byte while the slave shifts the register contents out.

The serial inputs are brought into the system clock domain through a two-stage synchronizer. Their edges are detected there, so the serial clock must run well below the system clock. The value of every register is presented in parallel on `regs_o` for the logic that uses it. A power controller can block writes to any register through a per-register lock input.

Top module: `spi_cfg_slave`

## Requirements
- R1: After reset every register reads 0x00, `regs_o` is all zero and `sdo_o` is low.
- R2: A frame carries, MSB first on `sdi_i` and sampled on rising `sck_i` edges, the 6-bit address, a direction bit (1 = write), a fixed bit that must be 1, and 8 data bits. On a write frame, the 16th rising edge stores the data in the addressed register, which appears in `regs_o[8*a +: 8]`.
- R3: On a read frame (direction 0), the slave drives the register value MSB first on `sdo_o` during the last 8 bits. A new bit is driven after each falling edge that follows rising edges 8 to 15, so the host samples it on rising edges 9 to 16.
- R4: With the default mask, addresses 0x00 to 0x1F and 0x2A are implemented. Any other address reads 0x00, ignores writes, and keeps its `regs_o` slice at zero.
- R5: If `csn_i` rises before the 16th rising edge, the frame is discarded and no register changes.
- R6: While `wr_lock_i[a]` is 1, writes to address a leave it unchanged, but reads of it still return its value.
- R7: A frame whose fixed bit is 0 is ignored. A write of that form changes nothing, and a read of that form returns 0x00.
- R8: `sdo_o` is low whenever `csn_i` is high.
- R9: Clock edges after the 16th within one select window have no effect. A longer frame acts on its first 16 bits only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock, idles low |
| csn_i | input | 1 | Select, active low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| wr_lock_i | input | 64 | Per-register write inhibit |
| regs_o | output | 512 | All registers, address a in bits [8a+7:8a] |

## Verification
On every cycle, the assertions check four things:
- `sdo_o` stays low while select is high, and it changes only after a detected falling clock edge or a select release.
- A write strobe occurs only when the bit counter has completed the frame.
- A locked register holds its value across a write strobe.
- An unlocked, implemented register takes the written byte.

Only the bench scenarios can show the rest. These are the serial field order, the readback of each address bit by bit, the treatment of unimplemented addresses, and the discarding of truncated frames and frames with a bad fixed bit. They also cover over-long frames and the ignoring of their extra bits.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NREG   = 1 << ADDR_W;
  localparam int unsigned HDR_BITS   = ADDR_W + 2;
  localparam int unsigned FRAME_BITS = HDR_BITS + DATA_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [NREG-1:0] DEF_IMPL = 64'h0000_0400_FFFF_FFFF;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1, s2;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
    end else begin
      s1 <= d_i;
      s2 <= s1;
    end
  end
  assign q_o = s2;
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_s_i,
  input  logic              csn_s_i,
  input  logic              sdi_s_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o
);
  localparam logic [CNT_W-1:0] C_HDR_M1 = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] C_HDR    = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] C_LAST   = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] C_FULL   = CNT_W'(FRAME_BITS);

  logic                  sck_q, rise, fall;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-2:0] shift;
  logic                  rd_ok;
  logic [DATA_W-1:0]     tx;

  assign rise = sck_s_i & ~sck_q;
  assign fall = ~sck_s_i & sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s_i;
  end

  // receive side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt       <= '0;
      shift     <= '0;
      rd_ok     <= 1'b0;
      rd_addr_o <= '0;
      wr_o      <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_o <= 1'b0;
      if (csn_s_i) begin
        cnt   <= '0;
        shift <= '0;
        rd_ok <= 1'b0;
      end else if (rise && cnt < C_FULL) begin
        shift <= {shift[FRAME_BITS-3:0], sdi_s_i};
        cnt   <= cnt + 1'b1;
        if (cnt == C_HDR_M1) begin
          rd_addr_o <= shift[HDR_BITS-2:1];
          rd_ok     <= ~shift[0] & sdi_s_i;
        end
        if (cnt == C_LAST) begin
          wr_o      <= shift[DATA_W] & shift[DATA_W-1];
          wr_addr_o <= shift[FRAME_BITS-2:DATA_W+1];
          wr_data_o <= {shift[DATA_W-2:0], sdi_s_i};
        end
      end
    end
  end

  // transmit side, updated after falling edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdo_o <= 1'b0;
      tx    <= '0;
    end else if (csn_s_i) begin
      sdo_o <= 1'b0;
    end else if (fall) begin
      if (cnt == C_HDR) begin
        sdo_o <= rd_ok & rd_data_i[DATA_W-1];
        tx    <= {rd_data_i[DATA_W-2:0], 1'b0};
      end else if (cnt > C_HDR && cnt < C_FULL) begin
        sdo_o <= rd_ok & tx[DATA_W-1];
        tx    <= {tx[DATA_W-2:0], 1'b0};
      end else begin
        sdo_o <= 1'b0;
      end
    end
  end

  p_sdo_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s_i && $past(csn_s_i) |-> !sdo_o);
  p_sdo_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> $past(fall || csn_s_i));
  p_wr_full_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> cnt == C_FULL);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import spi_cfg_pkg::*;
#(
  parameter logic [NREG-1:0] IMPL_MASK = DEF_IMPL
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [NREG-1:0]        wr_lock_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic [NREG*DATA_W-1:0] regs_o
);
  logic [NREG-1:0][DATA_W-1:0] q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (IMPL_MASK[i]) begin : g_impl
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r <= '0;
        else if (wr_i && wr_addr_i == ADDR_W'(i) && !wr_lock_i[i]) r <= wr_data_i;
      end
      assign q[i] = r;
    end else begin : g_none
      assign q[i] = '0;
    end
  end

  assign regs_o    = q;
  assign rd_data_o = q[rd_addr_i];

  p_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wr_lock_i[wr_addr_i] |=> q[$past(wr_addr_i)] == $past(q[wr_addr_i]));
  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !wr_lock_i[wr_addr_i] && IMPL_MASK[wr_addr_i]
    |=> q[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter logic [NREG-1:0] IMPL_MASK = DEF_IMPL
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sck_i,
  input  logic                   csn_i,
  input  logic                   sdi_i,
  output logic                   sdo_o,
  input  logic [NREG-1:0]        wr_lock_i,
  output logic [NREG*DATA_W-1:0] regs_o
);
  logic sck_s, csn_s, sdi_s;
  logic wr;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({sck_i, csn_i, sdi_i}), .q_o({sck_s, csn_s, sdi_s})
  );

  spi_frame u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sck_s_i(sck_s), .csn_s_i(csn_s), .sdi_s_i(sdi_s),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_o(wr), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sdo_o(sdo_o)
  );

  cfg_reg_bank #(.IMPL_MASK(IMPL_MASK)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wr_lock_i(wr_lock_i), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .regs_o(regs_o)
  );
endmodule

// File: tb/spi_cfg_slave_test.sv
module spi_cfg_slave_test;
  localparam int HALF = 6;
  localparam logic [63:0] IMPL = 64'h0000_0400_FFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic sdo;
  logic [63:0]  lock = '0;
  logic [511:0] regs;
  logic [7:0]   model [64];
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  spi_cfg_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .sdi_i(sdi),
    .sdo_o(sdo), .wr_lock_i(lock), .regs_o(regs)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [5:0] a, input logic wr, input logic fix,
                      input logic [7:0] d, input int nbits, output logic [7:0] rd);
    logic [15:0] fr;
    fr = {a, wr, fix, d};
    rd = '0;
    @(negedge clk);
    csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? fr[15-i] : 1'b1;
      wait_clk(HALF);
      if (i >= 8 && i < 16) rd[15-i] = sdo;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(HALF);
    chk("R8 sdo idle", {7'd0, sdo}, 8'h00);
  endtask

  task automatic chk_all(input string tag);
    for (int a = 0; a < 64; a++) chk(tag, regs[8*a +: 8], model[a]);
  endtask

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'(a * 53 + 17 + k * 91) | 8'h01;
  endfunction

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    for (int a = 0; a < 64; a++) model[a] = 8'h00;
    wait_clk(5);
    chk_all("R1 reset");
    chk("R1 sdo reset", {7'd0, sdo}, 8'h00);
    rst_n = 1'b1;
    wait_clk(5);

    // R2/R4: write every address
    for (int a = 0; a < 64; a++) begin
      xfer(6'(a), 1'b1, 1'b1, pat(a, 0), 16, rd);
      if (IMPL[a]) model[a] = pat(a, 0);
      chk(IMPL[a] ? "R2 write" : "R4 unimpl write", regs[8*a +: 8], model[a]);
    end
    chk_all("R4 bank after sweep");

    // R3/R4: read every address
    for (int a = 0; a < 64; a++) begin
      xfer(6'(a), 1'b0, 1'b1, 8'hA5, 16, rd);
      chk(IMPL[a] ? "R3 read" : "R4 unimpl read", rd, model[a]);
    end

    // R6: lock odd addresses
    lock = 64'hAAAA_AAAA_AAAA_AAAA;
    for (int a = 0; a < 64; a++) begin
      xfer(6'(a), 1'b1, 1'b1, pat(a, 1), 16, rd);
      if (IMPL[a] && !lock[a]) model[a] = pat(a, 1);
    end
    chk_all("R6 lock");
    for (int a = 1; a < 64; a += 2) begin
      xfer(6'(a), 1'b0, 1'b1, 8'h00, 16, rd);
      chk("R6 locked read", rd, model[a]);
    end
    lock = '0;

    // R5: truncated frames
    for (int n = 1; n < 16; n++) xfer(6'(n), 1'b1, 1'b1, 8'h5A, n, rd);
    chk_all("R5 truncated");

    // R7: fixed bit cleared
    xfer(6'd3, 1'b1, 1'b0, 8'h3C, 16, rd);
    chk_all("R7 bad fixed write");
    xfer(6'd3, 1'b0, 1'b0, 8'h00, 16, rd);
    chk("R7 bad fixed read", rd, 8'h00);

    // R9: over-long frames
    xfer(6'd7, 1'b1, 1'b1, 8'h42, 24, rd);
    model[7] = 8'h42;
    chk_all("R9 long write");
    xfer(6'h2A, 1'b1, 1'b1, 8'h81, 20, rd);
    model[42] = 8'h81;
    xfer(6'h2A, 1'b0, 1'b1, 8'h00, 22, rd);
    chk("R9 long read", rd, 8'h81);
    chk_all("R9 bank");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule